// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs bus transfers for a 16-bit processor core on a shared bus. The same sixteen lines carry the address first and then the data. A control strobe marks the address as valid. A read strobe or a write strobe then marks the data phase. The addressed slave ends the data phase by asserting a reply. All bus strobes are active low.

The core issues one request at a time while `ready` is high. A request is a read, a word write, a byte write or an interrupt-vector fetch. When the transfer finishes, the block pulses `done` for one cycle and holds the fetched word on `rdata`.

If the slave never replies, the block abandons the cycle after a fixed number of strobe cycles. It then reports a bus error and presents trap vector 004 (octal). The vector fetch has no address phase. It raises the read strobe together with an acknowledge line so that the interrupting device can place its vector on the bus.

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: The cycle after a read or write request is accepted is the address phase. In that cycle `ad_oe` is 1, `ad_o` equals the request address and `sync_n` is still 1.
- R2: In the next cycle `sync_n` goes to 0 while the address is still driven. `sync_n` stays 0 until the slave removes its reply.
- R3: A read drives `din_n` low with `ad_oe` at 0. The strobe is held for exactly D cycles when the slave replies in its D-th strobe cycle. `rdata` then holds the value that was on `ad_i` while the reply was seen.
- R4: A write drives `dout_n` low, with `ad_oe` at 1 and `ad_o` equal to the write data.
- R5: `wtbt_n` is 0 during the data phase of byte writes, at odd and even addresses alike. It is 1 in every other cycle.
- R6: If no reply arrives, the strobe is held for exactly 64 cycles. The cycle then ends with `bus_err`=1 and `trap_vec`=16'o000004 alongside `done`. A reply first seen in the 64th strobe cycle still completes normally.
- R7: A vector fetch drives `din_n` and `iako_n` low and never asserts `sync_n`. `rdata` returns the vector that was on `ad_i`.
- R8: After the strobe is released, `done` waits for `rply_n` to go high. `done` then pulses for one cycle, and `ready` is 1 in the cycle after it.
- R9: The timeout count restarts for every cycle, so a timeout never shortens the next cycle.
- R10: `bsy_n` is 0 from the address phase through the data phase. It is 1 at `done` and in idle.
- R11: After reset all strobes are 1, `ad_oe` is 0 and `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted while ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | Byte-sized write |
| req_vector | input | 1 | Interrupt-vector fetch |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 16 | Write data |
| ready | output | 1 | Idle, can accept a request |
| done | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Completion was a no-reply timeout |
| trap_vec | output | 16 | Trap vector when bus_err, else 0 |
| rdata | output | 16 | Read or vector data |
| ad_o | output | 16 | Shared lines, driven value |
| ad_oe | output | 1 | Shared lines output enable |
| ad_i | input | 16 | Shared lines, received value |
| sync_n | output | 1 | Address-valid / cycle strobe |
| din_n | output | 1 | Read strobe |
| dout_n | output | 1 | Write strobe |
| wtbt_n | output | 1 | Byte-write marker |
| iako_n | output | 1 | Interrupt acknowledge |
| bsy_n | output | 1 | Bus busy |
| rply_n | input | 1 | Slave reply |

## Verification
Random reads, word writes, byte writes and vector fetches are issued against a slave model. The model replies after a random delay and holds the reply for a random time. This separates the three kinds of strobe and the treatment of the byte marker. It also shows that `done` tracks the release of the reply rather than the strobe. Reply delays of 64 and 65 cycles, and a slave that never answers, bracket the timeout boundary. A short read that follows a timeout shows that the counter restarts.

// File: rtl/mbus_pkg.sv
// Shared types for the multiplexed bus cycle controller.
// Assumes one outstanding transfer at a time.
package mbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a request
        ST_ADDR,   // address driven, cycle strobe not yet asserted
        ST_LATCH,  // address driven, cycle strobe asserted
        ST_DATA,   // read/write/vector strobe active, waiting for reply
        ST_END,    // strobe released, waiting for reply removal
        ST_FIN     // completion pulse
    } mbus_state_e;
endpackage

// File: rtl/mbus_timeout.sv
// No-reply watchdog: counts data-phase cycles and flags the last allowed one.
// Assumes run stays high only during the data phase; count clears otherwise.
module mbus_timeout #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Count strobe cycles, restart whenever the data phase is left
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != CW'(LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Last allowed strobe cycle is the LIMIT-th one
    always_comb expired = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/mbus_req_hold.sv
// Holds the accepted request for the whole cycle and captures returned data.
// Assumes load only pulses in idle; a vector fetch is never treated as a write.
module mbus_req_hold #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          in_write,
    input  logic          in_byte,
    input  logic          in_vector,
    input  logic [DW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    input  logic          capture,
    input  logic [DW-1:0] bus_in,
    output logic          q_write,
    output logic          q_byte,
    output logic          q_vector,
    output logic [DW-1:0] q_addr,
    output logic [DW-1:0] q_wdata,
    output logic [DW-1:0] q_rdata
);
    // Latch request fields when a cycle starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_write  <= 1'b0;
            q_byte   <= 1'b0;
            q_vector <= 1'b0;
            q_addr   <= '0;
            q_wdata  <= '0;
        end else if (load) begin
            q_write  <= in_write && !in_vector;
            q_byte   <= in_byte && in_write && !in_vector;
            q_vector <= in_vector;
            q_addr   <= in_addr;
            q_wdata  <= in_wdata;
        end
    end

    // Sample the shared lines on the edge where the reply is seen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_rdata <= '0;
        end else if (capture) begin
            q_rdata <= bus_in;
        end
    end
endmodule

// File: rtl/mbus_fsm.sv
// Cycle sequencer: address phase, data phase, reply handshake, completion.
// Assumes rply_n is already synchronous to clk.
module mbus_fsm
    import mbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_vector,
    input  logic        rply_n,
    input  logic        expired,
    output mbus_state_e state,
    output logic        err
);
    mbus_state_e nxt;

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid) nxt = req_vector ? ST_DATA : ST_ADDR;
            ST_ADDR:  nxt = ST_LATCH;
            ST_LATCH: nxt = ST_DATA;
            ST_DATA:  if (!rply_n || expired) nxt = ST_END;
            ST_END:   if (rply_n) nxt = ST_FIN;
            ST_FIN:   nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Record whether the data phase ended by timeout; a reply wins a tie
    always_ff @(posedge clk) begin
        if (!rst_n)                  err <= 1'b0;
        else if (state == ST_IDLE)   err <= 1'b0;
        else if (state == ST_DATA)   err <= rply_n && expired;
    end
endmodule

// File: rtl/mbus_cycle_ctrl.sv
// Top: multiplexed address/data bus cycle controller with no-reply timeout.
// Assumes the caller waits for ready before presenting the next request.
module mbus_cycle_ctrl
    import mbus_pkg::*;
#(
    parameter int          DW       = 16,
    parameter int          TIMEOUT  = 64,
    parameter logic [15:0] TRAP_VEC = 16'o000004
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_byte,
    input  logic          req_vector,
    input  logic [DW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ready,
    output logic          done,
    output logic          bus_err,
    output logic [DW-1:0] trap_vec,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe,
    input  logic [DW-1:0] ad_i,
    output logic          sync_n,
    output logic          din_n,
    output logic          dout_n,
    output logic          wtbt_n,
    output logic          iako_n,
    output logic          bsy_n,
    input  logic          rply_n
);
    mbus_state_e   state;
    logic          err, expired;
    logic          q_write, q_byte, q_vector;
    logic [DW-1:0] q_addr, q_wdata;
    logic          in_data, in_addr_ph;

    always_comb in_data    = (state == ST_DATA);
    always_comb in_addr_ph = (state == ST_ADDR) || (state == ST_LATCH);

    mbus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .rply_n(rply_n), .expired(expired), .state(state), .err(err)
    );

    mbus_timeout #(.LIMIT(TIMEOUT)) u_tmo (
        .clk(clk), .rst_n(rst_n), .run(in_data), .expired(expired)
    );

    mbus_req_hold #(.DW(DW)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(ready && req_valid),
        .in_write(req_write), .in_byte(req_byte), .in_vector(req_vector),
        .in_addr(req_addr), .in_wdata(req_wdata),
        .capture(in_data && !rply_n), .bus_in(ad_i),
        .q_write(q_write), .q_byte(q_byte), .q_vector(q_vector),
        .q_addr(q_addr), .q_wdata(q_wdata), .q_rdata(rdata)
    );

    // Decode bus strobes and core-side status from the sequencer state
    always_comb begin
        ready    = (state == ST_IDLE);
        done     = (state == ST_FIN);
        bus_err  = done && err;
        trap_vec = bus_err ? DW'(TRAP_VEC) : '0;
        ad_oe    = in_addr_ph || (in_data && q_write);
        ad_o     = in_addr_ph ? q_addr : (ad_oe ? q_wdata : '0);
        sync_n   = !(!q_vector && (in_addr_ph && state == ST_LATCH
                                   || in_data || state == ST_END));
        din_n    = !(in_data && !q_write);
        dout_n   = !(in_data && q_write);
        wtbt_n   = !(in_data && q_write && q_byte);
        iako_n   = !(in_data && q_vector);
        bsy_n    = !(in_addr_ph || in_data);
    end
endmodule

// File: rtl/mbus_cycle_ctrl_chk.sv
// Protocol checker for the bus cycle controller, bound to the top module.
module mbus_cycle_ctrl_chk #(
    parameter int TIMEOUT = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        din_n,
    input logic        dout_n,
    input logic        wtbt_n,
    input logic        iako_n,
    input logic        sync_n,
    input logic        bsy_n,
    input logic        ad_oe,
    input logic        done,
    input logic        bus_err,
    input logic [15:0] trap_vec,
    input logic        rply_n
);
    localparam int CW = $clog2(TIMEOUT + 2);
    logic [CW-1:0] strb_run;

    // Length of the current unbroken strobe run
    always_ff @(posedge clk) begin
        if (!rst_n || (din_n && dout_n)) strb_run <= '0;
        else if (strb_run != CW'(TIMEOUT + 1)) strb_run <= strb_run + 1'b1;
    end

    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!din_n && !dout_n));
    a_r4_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_n |-> ad_oe);
    a_r5_wtbt_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wtbt_n |-> !dout_n);
    a_r7_ack_with_read: assert property (@(posedge clk) disable iff (!rst_n)
        !iako_n |-> (!din_n && sync_n && !ad_oe));
    a_r10_busy_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!din_n || !dout_n) |-> !bsy_n);
    a_r8_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(rply_n) && bsy_n));
    a_r6_err_vector: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (done && trap_vec == 16'o000004));
    a_r6_strobe_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        strb_run <= CW'(TIMEOUT));
endmodule

bind mbus_cycle_ctrl mbus_cycle_ctrl_chk #(.TIMEOUT(TIMEOUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .din_n(din_n), .dout_n(dout_n), .wtbt_n(wtbt_n),
    .iako_n(iako_n), .sync_n(sync_n), .bsy_n(bsy_n), .ad_oe(ad_oe),
    .done(done), .bus_err(bus_err), .trap_vec(trap_vec), .rply_n(rply_n)
);

// File: tb/test_mbus_cycle_ctrl.sv
`timescale 1ns/1ps
module test_mbus_cycle_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0, req_vector = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0, ad_i = '0;
    logic        rply_n = 1'b1;
    logic        ready, done, bus_err, ad_oe, sync_n, din_n, dout_n, wtbt_n, iako_n, bsy_n;
    logic [15:0] trap_vec, rdata, ad_o;
    int          checks = 0, errors = 0;

    always #2 clk = ~clk;

    mbus_cycle_ctrl i_mbus_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_byte(req_byte), .req_vector(req_vector), .req_addr(req_addr),
        .req_wdata(req_wdata), .ready(ready), .done(done), .bus_err(bus_err),
        .trap_vec(trap_vec), .rdata(rdata), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
        .sync_n(sync_n), .din_n(din_n), .dout_n(dout_n), .wtbt_n(wtbt_n),
        .iako_n(iako_n), .bsy_n(bsy_n), .rply_n(rply_n)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected outcome from the requirements
    function automatic bit exp_err(input int dly);
        return (dly == 0) || (dly > 64);
    endfunction
    function automatic int exp_strobes(input int dly);
        return exp_err(dly) ? 64 : dly;
    endfunction

    // One transfer; dly = reply in that strobe cycle (0 = never), rel = extra reply hold
    task automatic run_txn(input bit w, input bit b, input bit v, input logic [15:0] a,
                           input logic [15:0] wd, input logic [15:0] rd,
                           input int dly, input int rel);
        bit wr = w && !v;
        int strb = 0, post = 0, rel_left = rel;
        bit saw_sync = 0, fin = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_byte = b; req_vector = v;
        req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (!v) begin
            chk(ad_oe && ad_o == a && sync_n, "R1 address phase", {ad_oe, sync_n, ad_o}, {2'b11, a});
            chk(!bsy_n, "R10 busy in address phase", bsy_n, 0);
        end
        for (int i = 0; i < 400 && !fin; i++) begin
            bit strobe = !din_n || !dout_n;
            if (!v && !sync_n && !saw_sync) begin
                saw_sync = 1;
                chk(ad_oe && ad_o == a, "R2 address held with sync", ad_o, a);
            end
            if (v) chk(sync_n, "R7 no sync in vector fetch", sync_n, 1);
            if (done) begin
                fin = 1;
                post++;
                chk(bus_err == exp_err(dly), "R6 bus error flag", bus_err, exp_err(dly));
                chk(trap_vec == (exp_err(dly) ? 16'o4 : 16'h0), "R6 trap vector", trap_vec,
                    exp_err(dly) ? 16'o4 : 16'h0);
                chk(strb == exp_strobes(dly), "R3 R6 strobe length", strb, exp_strobes(dly));
                chk(post == (exp_err(dly) ? 2 : rel + 2), "R8 done after reply removal",
                    post, exp_err(dly) ? 2 : rel + 2);
                chk(bsy_n, "R10 idle bus at done", bsy_n, 1);
                if (!wr && !exp_err(dly))
                    chk(rdata == rd, v ? "R7 vector data" : "R3 read data", rdata, rd);
            end else if (strobe) begin
                strb++;
                chk(din_n == wr && dout_n == !wr, "R3 R4 strobe select", {din_n, dout_n}, {wr, !wr});
                chk(iako_n == !v, "R7 acknowledge", iako_n, !v);
                chk(wtbt_n == !(wr && b), "R5 byte marker", wtbt_n, !(wr && b));
                if (wr) chk(ad_oe && ad_o == wd, "R4 write data", ad_o, wd);
                else    chk(!ad_oe, "R3 lines released on read", ad_oe, 0);
                if (strb == dly) begin rply_n = 1'b0; ad_i = rd; end
            end else if (strb > 0) begin
                post++;
                chk(!done && bsy_n, "R8 R10 waiting for release", {done, bsy_n}, 2'b01);
                if (!v) chk(!sync_n, "R2 sync held until release", sync_n, 0);
                if (!rply_n) begin
                    if (rel_left == 0) begin rply_n = 1'b1; ad_i = '0; end
                    else rel_left--;
                end
            end else begin
                chk(wtbt_n, "R5 no byte marker outside data", wtbt_n, 1);
            end
            if (!fin) @(negedge clk);
        end
        chk(fin, "R8 transfer completed", fin, 1);
        @(negedge clk);
        chk(ready, "R8 ready after done", ready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'h5eed);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sync_n && din_n && dout_n && wtbt_n && iako_n && bsy_n && !ad_oe && ready,
            "R11 reset state", {sync_n, din_n, dout_n, wtbt_n, iako_n, bsy_n, ad_oe, ready},
            8'b11111101);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready && sync_n, "R11 idle after reset", {ready, sync_n}, 2'b11);
        // directed corners
        run_txn(0, 0, 0, 16'o1000, 16'h0, 16'hA5C3, 1, 0);
        run_txn(1, 1, 0, 16'o1001, 16'h00FE, 16'h0, 3, 2);
        run_txn(1, 0, 0, 16'o2000, 16'h1234, 16'h0, 2, 0);
        run_txn(0, 0, 1, 16'h0, 16'h0, 16'o000060, 2, 1);
        run_txn(0, 0, 0, 16'o3000, 16'h0, 16'hBEEF, 64, 0);   // R6 last allowed cycle
        run_txn(0, 0, 0, 16'o3002, 16'h0, 16'hDEAD, 65, 0);   // R6 just too late
        run_txn(1, 0, 0, 16'o3004, 16'h7777, 16'h0, 0, 0);    // R6 never replies
        run_txn(0, 0, 0, 16'o3006, 16'h0, 16'h4242, 40, 0);   // R9 fresh count
        run_txn(0, 0, 0, 16'o3010, 16'h0, 16'h0F0F, 63, 1);   // R9 again
        // random mix
        for (int n = 0; n < 60; n++) begin
            bit v = ($urandom % 8) == 0;
            bit w = $urandom % 2;
            bit b = $urandom % 2;
            int dly = (($urandom % 10) == 0) ? 0 : 1 + ($urandom % 20);
            run_txn(w, b, v, 16'($urandom), 16'($urandom), 16'($urandom), dly, $urandom % 4);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule